// File: doc/BRIEF.md
# Two-Wire Serial Target with Region-Wrapping Address Pointer

This block is the bus-facing end of a small byte memory that is split into regions: eight scratchpad blocks of 256 bytes each, one nonvolatile-configuration region and one volatile-configuration region. A controller on a two-wire serial bus (I2C-style, open-drain SDA) addresses the block, sets a word offset and then streams bytes in or out. The block turns those bus transfers into single-cycle read and write strobes on a synchronous memory port. It keeps one address pointer, made of a 4-bit region code and an 8-bit offset. The pointer steps after every data byte, and each kind of region has its own rule for what happens past its last word.

Each line passes through a two-stage synchronizer and is sampled on the system clock. START and STOP are recognised whenever they occur. The first byte of a transfer holds a 3-bit identity field, a 4-bit region code and a direction bit. For a write (direction 0), the next byte is the word offset. The region code and offset load the pointer, and the bytes that follow are stored at consecutive addresses. For a read (direction 1), bytes are returned from the pointer as it stands. A random read is therefore a write of the offset, then a repeated START, then a read. A current-address read is a read on its own.

The controller is one state machine. From ST_IDLE, a START moves it to ST_DEV, and a START from any other state does the same. After eight bits, ST_DEV moves to ST_ACK_DEV on an address hit and to ST_IGNORE on a miss. ST_ACK_DEV moves to ST_WADR for a write and to ST_RDAT for a read. ST_WADR moves to ST_ACK_WADR, which moves to ST_WDAT. ST_WDAT and ST_ACK_WDAT alternate, one pass per stored byte. ST_RDAT moves to ST_MACK after eight bits. ST_MACK returns to ST_RDAT when the controller acknowledges and goes to ST_IGNORE when it does not. A STOP from any state returns the machine to ST_IDLE.

Top module: `twi_region_target`

## Requirements
- R1: A falling SDA while SCL is high (START) restarts reception of the address byte from its first bit, even in the middle of a byte. A rising SDA while SCL is high (STOP) returns the block to idle.
- R2: The address byte is bits [7:5] identity (must equal 3'b101), bits [4:1] region code, and bit [0] direction. A byte with a different identity, or with a region code above 9, gets no acknowledge. The block then leaves SDA released and writes nothing until the next START.
- R3: In a write, the block acknowledges the offset byte and each data byte. It stores each data byte with one single-cycle write strobe, at consecutive pointer addresses beginning at {region, offset}.
- R4: A random read (offset write, repeated START, read address byte) returns the byte at the offset just written, in the region just selected.
- R5: A read address byte without an offset phase returns the byte at the current pointer. After a read this is one past the last byte sent; after a write it is one past the last byte stored.
- R6: During a read, a controller acknowledge after a byte makes the block send the byte at the next address. A controller non-acknowledge ends the output, with SDA released up to and after the STOP.
- R7: For region codes 0 to 7 (scratchpad), stepping past offset FFh goes to offset 00h of the next block, and stepping past offset FFh of block 7 goes to block 0 offset 00h. The memory address is {region, offset}.
- R8: For region code 8 (nonvolatile configuration, 16 words), stepping past offset 0Fh returns the pointer to offset 00h of the same region.
- R9: For region code 9 (volatile configuration, 8 words), stepping past offset 07h returns the pointer to offset 00h of the same region.
- R10: The SDA output is an open-drain enable, asserted only to pull the line low. It is asserted only in acknowledge slots and for 0 bits of read data, and it changes only while the synchronized SCL is low.
- R11: After reset, the pointer is region 0 offset 00h, SDA is released, and neither memory strobe is active.
- R12: The read strobe and the write strobe are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| mem_addr | output | 12 | Memory address {region code, offset} |
| mem_rd | output | 1 | Single-cycle read strobe; data due on mem_rdata one cycle later |
| mem_wr | output | 1 | Single-cycle write strobe |
| mem_wdata | output | 8 | Byte to store with mem_wr |
| mem_rdata | input | 8 | Byte returned by the memory |

## Verification
Some properties are checked on every cycle. START always lands in address reception with a cleared bit count, and STOP always lands in idle. A write strobe only appears in the data-acknowledge slot. A missed address never produces a strobe. The two strobes never overlap. SDA drive changes only while SCL is low. The pointer carries across scratchpad blocks and wraps inside each configuration region. Other behaviour needs the bench's bus scenarios: the acknowledge pattern a given address byte earns, the order of bytes in the memory, the data returned after a repeated START or with no offset phase, and where the pointer is left after a non-acknowledge or an ignored transfer.

// File: rtl/twi_pkg.sv
package twi_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_ACK_DEV,
        ST_WADR,
        ST_ACK_WADR,
        ST_WDAT,
        ST_ACK_WDAT,
        ST_RDAT,
        ST_MACK,
        ST_IGNORE
    } twi_state_e;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_q;
    logic              sda_q;

    // Synchronizer chains; the idle bus level is high.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            for (int i = STAGES - 1; i > 0; i--) begin
                scl_ff[i] <= scl_ff[i-1];
                sda_ff[i] <= sda_ff[i-1];
            end
            scl_ff[0] <= scl_i;
            sda_ff[0] <= sda_i;
            scl_q     <= scl_s;
            sda_q     <= sda_s;
        end
    end

    assign scl_s    = scl_ff[STAGES-1];
    assign sda_s    = sda_ff[STAGES-1];
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_p  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_p   = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/twi_ptr.sv
module twi_ptr #(
    parameter int REGION_W   = 4,
    parameter int OFF_W      = 8,
    parameter int NUM_BLOCKS = 8,
    parameter int NV_WORDS   = 16,
    parameter int V_WORDS    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [REGION_W-1:0] load_region,
    input  logic [OFF_W-1:0]    load_off,
    input  logic                inc,
    output logic [REGION_W-1:0] region,
    output logic [OFF_W-1:0]    offset
);

    localparam logic [REGION_W-1:0] LAST_BLK = REGION_W'(NUM_BLOCKS - 1);
    localparam logic [REGION_W-1:0] REG_NV   = REGION_W'(NUM_BLOCKS);
    localparam logic [REGION_W-1:0] REG_V    = REGION_W'(NUM_BLOCKS + 1);
    localparam logic [OFF_W-1:0]    NV_LAST  = OFF_W'(NV_WORDS - 1);
    localparam logic [OFF_W-1:0]    V_LAST   = OFF_W'(V_WORDS - 1);

    logic [REGION_W-1:0] region_n;
    logic [OFF_W-1:0]    offset_n;

    // Step rule: scratchpad blocks form one ring, each config region its own.
    always_comb begin
        region_n = region;
        offset_n = offset + 1'b1;
        if (region <= LAST_BLK) begin
            if (offset == '1) begin
                offset_n = '0;
                region_n = (region == LAST_BLK) ? '0 : region + 1'b1;
            end
        end else if (region == REG_NV) begin
            if (offset >= NV_LAST) offset_n = '0;
        end else begin
            if (offset >= V_LAST) offset_n = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            region <= '0;
            offset <= '0;
        end else if (load) begin
            region <= load_region;
            offset <= load_off;
        end else if (inc) begin
            region <= region_n;
            offset <= offset_n;
        end
    end

    AST_BLK_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !load && region < LAST_BLK && offset == '1
        |=> offset == '0 && region == $past(region) + 1'b1) else $error("block carry"); // R7
    AST_BLK_RING: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !load && region == LAST_BLK && offset == '1
        |=> offset == '0 && region == '0) else $error("last block ring"); // R7
    AST_NV_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !load && region == REG_NV && offset == NV_LAST
        |=> offset == '0 && region == REG_NV) else $error("nv wrap"); // R8
    AST_V_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc && !load && region == REG_V && offset == V_LAST
        |=> offset == '0 && region == REG_V) else $error("v wrap"); // R9

endmodule

// File: rtl/twi_region_target.sv
module twi_region_target
    import twi_pkg::*;
#(
    parameter int                  DEV_ID_W    = 3,
    parameter logic [DEV_ID_W-1:0] DEV_ID      = 3'b101,
    parameter int                  SYNC_STAGES = 2,
    parameter int                  REGION_W    = 4,
    parameter int                  OFF_W       = 8,
    parameter int                  NUM_BLOCKS  = 8,
    parameter int                  NV_WORDS    = 16,
    parameter int                  V_WORDS     = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    output logic [REGION_W+OFF_W-1:0] mem_addr,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [7:0]                mem_wdata,
    input  logic [7:0]                mem_rdata
);

    // Address byte: identity | region code | direction (DEV_ID_W + REGION_W = 7).
    localparam logic [REGION_W-1:0] REG_MAX = REGION_W'(NUM_BLOCKS + 1);
    localparam logic [3:0]          BIT_END = 4'd8;

    logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_p  (start_p),
        .stop_p   (stop_p)
    );

    twi_state_e          state, state_n;
    logic [3:0]          cnt;
    logic [7:0]          shreg;
    logic [7:0]          tx_sh;
    logic [7:0]          rbuf;
    logic                rw_q, mack_q, rd_pend;
    logic [REGION_W-1:0] pend_region;
    logic [REGION_W-1:0] region;
    logic [OFF_W-1:0]    offset;

    logic quiet, byte_end, addr_hit;
    logic ld_ptr, inc_ptr, rd_first, rd_next, load_tx, wr_hit;

    assign quiet    = !start_p && !stop_p;
    assign byte_end = scl_fall && (cnt == BIT_END) && quiet;
    assign addr_hit = (shreg[7 -: DEV_ID_W] == DEV_ID) && (shreg[REGION_W:1] <= REG_MAX);
    assign ld_ptr   = (state == ST_WADR) && byte_end;
    assign inc_ptr  = mem_wr || ((state == ST_RDAT) && byte_end);
    assign rd_first = (state == ST_DEV) && byte_end && addr_hit && shreg[0];
    assign rd_next  = (state == ST_MACK) && scl_rise && quiet;
    assign wr_hit   = (state == ST_WDAT) && byte_end;
    assign load_tx  = quiet && scl_fall &&
                      (((state == ST_ACK_DEV) && rw_q) || ((state == ST_MACK) && mack_q));

    twi_ptr #(
        .REGION_W   (REGION_W),
        .OFF_W      (OFF_W),
        .NUM_BLOCKS (NUM_BLOCKS),
        .NV_WORDS   (NV_WORDS),
        .V_WORDS    (V_WORDS)
    ) u_ptr (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (ld_ptr),
        .load_region (pend_region),
        .load_off    (shreg[OFF_W-1:0]),
        .inc         (inc_ptr),
        .region      (region),
        .offset      (offset)
    );

    assign mem_addr = {region, offset};

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Transitions; bus conditions take priority over bit timing.
    always_comb begin
        state_n = state;
        if (start_p) begin
            state_n = ST_DEV;
        end else if (stop_p) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_n = ST_IDLE;
                ST_DEV:      if (byte_end) state_n = addr_hit ? ST_ACK_DEV : ST_IGNORE;
                ST_ACK_DEV:  if (scl_fall) state_n = rw_q ? ST_RDAT : ST_WADR;
                ST_WADR:     if (byte_end) state_n = ST_ACK_WADR;
                ST_ACK_WADR: if (scl_fall) state_n = ST_WDAT;
                ST_WDAT:     if (byte_end) state_n = ST_ACK_WDAT;
                ST_ACK_WDAT: if (scl_fall) state_n = ST_WDAT;
                ST_RDAT:     if (byte_end) state_n = ST_MACK;
                ST_MACK:     if (scl_fall) state_n = mack_q ? ST_RDAT : ST_IGNORE;
                ST_IGNORE:   state_n = ST_IGNORE;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    // Bit counter, shifters and read buffer.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt         <= '0;
            shreg       <= '0;
            tx_sh       <= '1;
            rbuf        <= '0;
            rw_q        <= 1'b0;
            mack_q      <= 1'b0;
            rd_pend     <= 1'b0;
            pend_region <= '0;
        end else begin
            if (!quiet) begin
                cnt <= '0;
            end else if (scl_rise && (state inside {ST_DEV, ST_WADR, ST_WDAT, ST_RDAT})) begin
                cnt   <= cnt + 1'b1;
                shreg <= {shreg[6:0], sda_s};
            end else if (byte_end) begin
                cnt <= '0;
            end
            if (rd_next) mack_q <= ~sda_s;
            if ((state == ST_DEV) && byte_end) begin
                rw_q        <= shreg[0];
                pend_region <= shreg[REGION_W:1];
            end
            rd_pend <= mem_rd;
            if (rd_pend) rbuf <= mem_rdata;
            if (load_tx)
                tx_sh <= rbuf;
            else if ((state == ST_RDAT) && scl_fall && quiet && (cnt != BIT_END))
                tx_sh <= {tx_sh[6:0], 1'b1};
        end
    end

    // Memory strobes.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mem_rd    <= 1'b0;
            mem_wr    <= 1'b0;
            mem_wdata <= '0;
        end else begin
            mem_rd <= rd_first || rd_next;
            mem_wr <= wr_hit;
            if (wr_hit) mem_wdata <= shreg;
        end
    end

    // Open-drain drive: acknowledge slots and zero bits of read data.
    always_comb begin
        unique case (state)
            ST_ACK_DEV, ST_ACK_WADR, ST_ACK_WDAT: sda_oe = 1'b1;
            ST_RDAT:                              sda_oe = ~tx_sh[7];
            default:                              sda_oe = 1'b0;
        endcase
    end

    AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> state == ST_DEV && cnt == 4'd0) else $error("start"); // R1
    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p && !start_p |=> state == ST_IDLE) else $error("stop"); // R1
    AST_IGNORE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_IGNORE |-> !mem_wr && !mem_rd) else $error("ignore strobe"); // R2
    AST_WR_IN_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> state == ST_ACK_WDAT) else $error("write slot"); // R3
    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s) else $error("sda change with scl high"); // R10
    AST_RDWR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)) else $error("strobe overlap"); // R12

endmodule

// File: tb/sim_twi_region_target.sv
module sim_twi_region_target;

    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [11:0] mem_addr;
    logic       mem_rd, mem_wr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    wire        sda_line = sda_m & ~sda_oe;

    always #5 clk = ~clk;

    twi_region_target u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    logic [7:0]  mem [0:4095];
    int          exp_mem [0:4095];
    int          exp_ptr = 0;
    int          checks = 0;
    int          fails = 0;
    bit          oe_ok = 1'b0;
    bit          live = 1'b0;
    logic [19:0] wr_log [$];
    logic [19:0] wr_exp [$];

    initial begin
        for (int i = 0; i < 4096; i++) begin
            mem[i]     = 8'((i * 37 + 5) & 255);
            exp_mem[i] = (i * 37 + 5) & 255;
        end
    end

    // Behavioural memory behind the port.
    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr];
    end

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // Per-clock comparison against the bench's allowed-drive window and strobe rules.
    always @(negedge clk) begin
        if (live) begin
            check("R10 drive window", int'(sda_oe && !oe_ok), 0);
            check("R12 strobe overlap", int'(mem_wr && mem_rd), 0);
            if (mem_wr) wr_log.push_back({mem_addr, mem_wdata});
        end
    end

    function automatic int nxt(input int a);
        int r = a >> 8;
        int o = a & 255;
        if (r < 8)  return (a + 1) % 2048;
        if (r == 8) return (o >= 15) ? (8 << 8) : a + 1;
        return (o >= 7) ? (9 << 8) : a + 1;
    endfunction

    function automatic logic [7:0] dev_w(input int r);
        return {3'b101, 4'(r), 1'b0};
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        r = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
        oe_ok = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] b, input bit exp_ack, input bit hold, input string rq);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            if (i == 0 && exp_ack) oe_ok = 1'b1;
            clk_bit(b[i], r);
        end
        clk_bit(1'b1, r);
        check(rq, int'(!r), int'(exp_ack));
        if (!hold) oe_ok = 1'b0;
    endtask

    task automatic rbyte(input bit ackm, output logic [7:0] d);
        logic r;
        oe_ok = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, r);
            d[i] = r;
        end
        oe_ok = 1'b0;
        sda_m = ~ackm; wq();
        scl_m = 1'b1; wq(); wq();
        scl_m = 1'b0;
        if (ackm) oe_ok = 1'b1;
        wq();
    endtask

    task automatic wr_txn(input int rg, input int off, input int n, input int base, input string rq);
        bus_start();
        wbyte(dev_w(rg), 1'b1, 1'b0, rq);
        wbyte(8'(off), 1'b1, 1'b0, rq);
        exp_ptr = rg * 256 + off;
        wr_log.delete();
        wr_exp.delete();
        for (int k = 0; k < n; k++) begin
            wbyte(8'((base + k) & 255), 1'b1, 1'b0, rq);
            wr_exp.push_back({12'(exp_ptr), 8'((base + k) & 255)});
            exp_mem[exp_ptr] = (base + k) & 255;
            exp_ptr = nxt(exp_ptr);
        end
        bus_stop();
        wq();
        check({rq, " write count"}, wr_log.size(), n);
        for (int k = 0; k < n && k < wr_log.size(); k++)
            check({rq, " write addr/data"}, int'(wr_log[k]), int'(wr_exp[k]));
    endtask

    task automatic rd_txn(input bit rnd, input int rg, input int off, input int n, input string rq);
        logic [7:0] d;
        bus_start();
        if (rnd) begin
            wbyte(dev_w(rg), 1'b1, 1'b0, rq);
            wbyte(8'(off), 1'b1, 1'b0, rq);
            exp_ptr = rg * 256 + off;
            bus_start();
        end
        wbyte(8'hA1, 1'b1, 1'b1, rq);
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, d);
            check({rq, " read data"}, int'(d), exp_mem[exp_ptr]);
            exp_ptr = nxt(exp_ptr);
        end
        bus_stop();
        wq();
        check("R6 released after read", int'(sda_oe), 0);
    endtask

    initial begin
        logic r;
        repeat (4) @(negedge clk);
        check("R11 sda_oe in reset", int'(sda_oe), 0);
        check("R11 strobes in reset", int'(mem_rd | mem_wr), 0);
        check("R11 address in reset", int'(mem_addr), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        live = 1'b1;

        rd_txn(1'b0, 0, 0, 1, "R11 R5 first current read");
        wr_txn(2, 8'hFE, 3, 8'h11, "R3 R7 block carry write");
        rd_txn(1'b1, 7, 8'hFF, 2, "R4 R6 R7 ring read");
        rd_txn(1'b0, 0, 0, 1, "R5 after read");
        wr_txn(8, 15, 2, 8'h5A, "R8 nv write wrap");
        rd_txn(1'b1, 8, 15, 3, "R8 nv read wrap");
        rd_txn(1'b1, 9, 7, 3, "R9 volatile read wrap");
        wr_txn(7, 8'hFF, 2, 8'hC0, "R3 R7 ring write");
        rd_txn(1'b0, 0, 0, 2, "R5 after write");

        // R2: identity mismatch, then out-of-range region code.
        wr_log.delete();
        bus_start();
        wbyte(8'hC4, 1'b0, 1'b0, "R2 identity miss");
        wbyte(8'h10, 1'b0, 1'b0, "R2 ignored offset");
        wbyte(8'h99, 1'b0, 1'b0, "R2 ignored data");
        bus_stop();
        bus_start();
        wbyte(8'hB4, 1'b0, 1'b0, "R2 region code 10");
        wbyte(8'h20, 1'b0, 1'b0, "R2 ignored offset");
        bus_stop();
        wq();
        check("R2 no writes", wr_log.size(), 0);
        rd_txn(1'b0, 0, 0, 1, "R2 pointer kept");

        // R1: START in the middle of a byte restarts address reception.
        bus_start();
        for (int i = 0; i < 4; i++) clk_bit(i[0], r);
        wr_txn(9, 3, 1, 8'h77, "R1 restart mid byte");
        check("R1 idle after stop", int'(sda_oe), 0);
        rd_txn(1'b1, 9, 3, 1, "R1 readback");

        live = 1'b0;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule